// File: doc/BRIEF.md
# Priority Crossbar for Wishbone Masters and Slaves

This block is a switch between four Wishbone bus masters and a parameterized number of Wishbone slaves, up to sixteen. Each master picks a slave with the upper four bits of its address. Every slave has its own arbiter. When several masters want the same free slave in the same cycle, the arbiter compares a 2-bit priority for each master, taken from a configuration word.

A connection is registered at the clock edge after the request. From then on the winning master is wired straight to its slave. Address, write data, byte selects, strobe, cycle and write enable go forward to the slave. Read data and the three termination signals come back to the master.

The connection stays in place until the master sees ack, err or rty, or until it drops its cycle signal. It cannot be taken away by a later request, whatever that request's priority. Masters that target different slaves are served at the same time.

Top module: `wb_prio_xbar`

## Requirements
- R1: The upper four address bits of a master, `m_adr[j*AW+AW-1 -: 4]`, give the index of the target slave. An index of NS or more connects to nothing.
- R2: A master that raises `m_cyc` toward a free slave with no competing request is connected after exactly one clock edge, and not in the same cycle.
- R3: If several masters request the same free slave in one cycle, the master whose field `cfg_prio[2j+1:2j]` holds the largest value is connected.
- R4: If several requesting masters share the largest priority value, the lowest-numbered of them is connected.
- R5: While connected, the slave sees the master's cyc, stb, we, address, write data and select lanes. The master sees the slave's read data, ack, err and rty, in the same cycle.
- R6: A connection ends at the clock edge where the slave drives ack, err or rty, or where the master's cyc is low. The slave is free in the following cycle, and a waiting master is connected one edge after that.
- R7: A connection is never preempted, not even by a master with a larger priority value.
- R8: A master with no connection sees ack, err, rty and read data at 0. A slave with no owner sees cyc and stb at 0.
- R9: Each slave arbitrates on its own, so different masters can be connected to different slaves at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prio | input | 2*NM | Priority field per master, 2 bits each |
| m_cyc | input | NM | Master cycle request |
| m_stb | input | NM | Master strobe |
| m_we | input | NM | Master write enable |
| m_adr | input | NM*AW | Master addresses |
| m_dat_w | input | NM*DW | Master write data |
| m_sel | input | NM*SW | Master byte selects |
| m_dat_r | output | NM*DW | Read data to masters |
| m_ack | output | NM | Ack to masters |
| m_err | output | NM | Error to masters |
| m_rty | output | NM | Retry to masters |
| s_cyc | output | NS | Cycle to slaves |
| s_stb | output | NS | Strobe to slaves |
| s_we | output | NS | Write enable to slaves |
| s_adr | output | NS*AW | Address to slaves |
| s_dat_w | output | NS*DW | Write data to slaves |
| s_sel | output | NS*SW | Byte selects to slaves |
| s_dat_r | input | NS*DW | Read data from slaves |
| s_ack | input | NS | Ack from slaves |
| s_err | input | NS | Error from slaves |
| s_rty | input | NS | Retry from slaves |

## Verification
Grants are registered, so the bench drives a request on a falling edge and first checks that the slave's cyc is still low in that same half cycle. It then checks the connection on the next falling edge, after one rising edge. The data and termination paths are combinational through an existing connection, so they are checked in the same half cycle as the slave's response. The release is visible one edge after a termination, and a waiting master is connected one edge later still. The bench samples at each of those points in turn, and its expected owner comes from comparing the priority fields.

// File: rtl/wb_prio_xbar.sv
module wb_prio_xbar #(
  parameter int NM   = 4,
  parameter int NS   = 16,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int SW   = DW / 8,
  parameter int SELW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2*NM-1:0]  cfg_prio,
  input  logic [NM-1:0]    m_cyc,
  input  logic [NM-1:0]    m_stb,
  input  logic [NM-1:0]    m_we,
  input  logic [NM*AW-1:0] m_adr,
  input  logic [NM*DW-1:0] m_dat_w,
  input  logic [NM*SW-1:0] m_sel,
  output logic [NM*DW-1:0] m_dat_r,
  output logic [NM-1:0]    m_ack,
  output logic [NM-1:0]    m_err,
  output logic [NM-1:0]    m_rty,
  output logic [NS-1:0]    s_cyc,
  output logic [NS-1:0]    s_stb,
  output logic [NS-1:0]    s_we,
  output logic [NS*AW-1:0] s_adr,
  output logic [NS*DW-1:0] s_dat_w,
  output logic [NS*SW-1:0] s_sel,
  input  logic [NS*DW-1:0] s_dat_r,
  input  logic [NS-1:0]    s_ack,
  input  logic [NS-1:0]    s_err,
  input  logic [NS-1:0]    s_rty
);
  localparam int IW = (NM > 1) ? $clog2(NM) : 1;

  logic [NS-1:0] own_v;
  logic [IW-1:0] own_id [NS];
  logic [NS-1:0] hit    [NM];
  logic [NM-1:0] busy;
  logic [NS-1:0] win_v;
  logic [IW-1:0] win_id [NS];
  logic [NS-1:0] done;

  always_comb begin
    for (int j = 0; j < NM; j++) begin
      for (int k = 0; k < NS; k++)
        hit[j][k] = own_v[k] && (own_id[k] == IW'(j));
      busy[j] = |hit[j];
    end
  end

  always_comb begin
    for (int k = 0; k < NS; k++) begin
      logic [1:0] best;
      best      = '0;
      win_v[k]  = 1'b0;
      win_id[k] = '0;
      for (int i = 0; i < NM; i++) begin
        if (m_cyc[i] && !busy[i] &&
            m_adr[i*AW+AW-1 -: SELW] == SELW'(k) &&
            (!win_v[k] || cfg_prio[2*i +: 2] > best)) begin
          win_v[k]  = 1'b1;
          win_id[k] = IW'(i);
          best      = cfg_prio[2*i +: 2];
        end
      end
    end
  end

  assign done = own_v & (s_ack | s_err | s_rty | ~s_cyc);

  always_ff @(posedge clk) begin
    for (int k = 0; k < NS; k++) begin
      if (!rst_n) begin
        own_v[k]  <= 1'b0;
        own_id[k] <= '0;
      end else if (done[k]) begin
        own_v[k]  <= 1'b0;
      end else if (!own_v[k] && win_v[k]) begin
        own_v[k]  <= 1'b1;
        own_id[k] <= win_id[k];
      end
    end
  end

  for (genvar k = 0; k < NS; k++) begin : g_slv
    assign s_cyc[k]           = own_v[k] & m_cyc[own_id[k]];
    assign s_stb[k]           = own_v[k] & m_stb[own_id[k]];
    assign s_we[k]            = m_we[own_id[k]];
    assign s_adr[k*AW +: AW]  = m_adr[own_id[k]*AW +: AW];
    assign s_dat_w[k*DW +: DW] = m_dat_w[own_id[k]*DW +: DW];
    assign s_sel[k*SW +: SW]  = m_sel[own_id[k]*SW +: SW];
  end

  always_comb begin
    m_dat_r = '0;
    m_ack   = '0;
    m_err   = '0;
    m_rty   = '0;
    for (int j = 0; j < NM; j++)
      for (int k = 0; k < NS; k++)
        if (hit[j][k]) begin
          m_dat_r[j*DW +: DW] = s_dat_r[k*DW +: DW];
          m_ack[j] = s_ack[k];
          m_err[j] = s_err[k];
          m_rty[j] = s_rty[k];
        end
  end
endmodule

// File: rtl/wb_prio_xbar_chk.sv
module wb_prio_xbar_chk #(
  parameter int NM = 4,
  parameter int NS = 16,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NM-1:0] m_cyc,
  input logic [NM-1:0] m_ack,
  input logic [NM-1:0] m_err,
  input logic [NM-1:0] m_rty,
  input logic [NS-1:0] s_cyc,
  input logic [NS-1:0] s_stb,
  input logic [NS-1:0] s_ack,
  input logic [NS-1:0] s_err,
  input logic [NS-1:0] s_rty,
  input logic [NS-1:0] own_v,
  input logic [IW-1:0] own_id [NS]
);
  logic [NS-1:0] link [NM];
  always_comb
    for (int j = 0; j < NM; j++)
      for (int k = 0; k < NS; k++)
        link[j][k] = own_v[k] && own_id[k] == IW'(j);

  for (genvar k = 0; k < NS; k++) begin : g_s
    a_r8_idle_slave: assert property (@(posedge clk) disable iff (!rst_n)
      !own_v[k] |-> !s_cyc[k] && !s_stb[k]);
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      own_v[k] && s_cyc[k] && (s_ack[k] || s_err[k] || s_rty[k]) |=> !own_v[k]);
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      own_v[k] && s_cyc[k] && !(s_ack[k] || s_err[k] || s_rty[k])
      |=> own_v[k] && own_id[k] == $past(own_id[k]));
  end

  for (genvar j = 0; j < NM; j++) begin : g_m
    a_r9_one_slave: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(link[j]) <= 1);
    a_r8_idle_master: assert property (@(posedge clk) disable iff (!rst_n)
      link[j] == '0 |-> !m_ack[j] && !m_err[j] && !m_rty[j]);
  end
endmodule

bind wb_prio_xbar wb_prio_xbar_chk #(.NM(NM), .NS(NS), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_cyc(m_cyc), .m_ack(m_ack), .m_err(m_err),
  .m_rty(m_rty), .s_cyc(s_cyc), .s_stb(s_stb), .s_ack(s_ack), .s_err(s_err),
  .s_rty(s_rty), .own_v(own_v), .own_id(own_id)
);

// File: tb/tb_wb_prio_xbar.sv
module tb_wb_prio_xbar;
  localparam int NM = 4, NS = 4, AW = 8, DW = 8, SW = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2*NM-1:0] cfg_prio = '0;
  logic [NM-1:0] m_cyc = '0, m_stb = '0, m_we = '0;
  logic [NM*AW-1:0] m_adr = '0;
  logic [NM*DW-1:0] m_dat_w = '0;
  logic [NM*SW-1:0] m_sel = '0;
  logic [NM*DW-1:0] m_dat_r;
  logic [NM-1:0] m_ack, m_err, m_rty;
  logic [NS-1:0] s_cyc, s_stb, s_we;
  logic [NS*AW-1:0] s_adr;
  logic [NS*DW-1:0] s_dat_w;
  logic [NS*SW-1:0] s_sel;
  logic [NS*DW-1:0] s_dat_r = '0;
  logic [NS-1:0] s_ack = '0, s_err = '0, s_rty = '0;

  int checks = 0, errors = 0;

  wb_prio_xbar #(.NM(NM), .NS(NS), .AW(AW), .DW(DW), .SW(SW)) dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic req_m(input int i, input int k);
    m_cyc[i] = 1'b1; m_stb[i] = 1'b1; m_we[i] = i[0];
    m_adr[i*AW +: AW] = {4'(k), 4'(i)};
    m_dat_w[i*DW +: DW] = 8'(16 * i + k + 1);
    m_sel[i] = 1'b1;
  endtask

  task automatic drop_m(input int i);
    m_cyc[i] = 1'b0; m_stb[i] = 1'b0;
  endtask

  function automatic int owner(input int k);
    return int'(s_adr[k*AW +: 4]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(s_cyc == 0 && s_stb == 0, "R8 reset slaves", int'(s_cyc), 0);
    chk(m_ack == 0 && m_err == 0 && m_rty == 0, "R8 reset masters", int'(m_ack), 0);

    for (int i = 0; i < NM; i++)
      for (int k = 0; k < NS; k++) begin
        req_m(i, k);
        #1 chk(s_cyc == 0, "R2 not same cycle", int'(s_cyc), 0);
        @(negedge clk);
        chk(s_cyc == 4'(1 << k), "R1 R2 decode", int'(s_cyc), 1 << k);
        chk(s_adr[k*AW +: AW] == {4'(k), 4'(i)} && s_dat_w[k*DW +: DW] == 8'(16*i+k+1)
            && s_we[k] == i[0] && s_sel[k] && s_stb[k], "R5 forward",
            int'(s_dat_w[k*DW +: DW]), 16*i+k+1);
        chk(m_ack[i] == 0, "R8 no ack before slave", int'(m_ack), 0);
        s_dat_r[k*DW +: DW] = 8'(8'hA0 + k);
        if (k == 1) s_err[k] = 1'b1; else if (k == 2) s_rty[k] = 1'b1; else s_ack[k] = 1'b1;
        #1 chk(m_dat_r[i*DW +: DW] == 8'(8'hA0 + k) && m_ack[i] == (k != 1 && k != 2)
               && m_err[i] == (k == 1) && m_rty[i] == (k == 2), "R5 return",
               int'({m_ack[i], m_err[i], m_rty[i]}), k);
        @(negedge clk);
        s_ack = '0; s_err = '0; s_rty = '0;
        drop_m(i);
        #1 chk(s_cyc == 0 && m_dat_r == 0, "R6 R8 released", int'(s_cyc), 0);
        @(negedge clk);
      end

    m_cyc[0] = 1'b1; m_stb[0] = 1'b1; m_adr[0 +: AW] = 8'h90;
    @(negedge clk); @(negedge clk);
    chk(s_cyc == 0 && m_ack == 0, "R1 out of range", int'(s_cyc), 0);
    drop_m(0);
    @(negedge clk);

    for (int a = 0; a < NM; a++)
      for (int b = a + 1; b < NM; b++)
        for (int pa = 0; pa < 4; pa++)
          for (int pb = 0; pb < 4; pb++) begin
            int w, l;
            cfg_prio = '0;
            cfg_prio[2*a +: 2] = 2'(pa);
            cfg_prio[2*b +: 2] = 2'(pb);
            w = (pb > pa) ? b : a;
            l = (w == a) ? b : a;
            req_m(a, 2); req_m(b, 2);
            @(negedge clk);
            if (pa != pb) chk(s_cyc[2] && owner(2) == w, "R3 priority", owner(2), w);
            else          chk(s_cyc[2] && owner(2) == w, "R4 tie", owner(2), w);
            s_ack[2] = 1'b1;
            @(negedge clk);
            s_ack[2] = 1'b0;
            drop_m(w);
            #1 chk(s_cyc[2] == 0, "R6 freed", int'(s_cyc), 0);
            @(negedge clk);
            chk(s_cyc[2] && owner(2) == l, "R6 waiter", owner(2), l);
            drop_m(l);
            @(negedge clk);
          end

    cfg_prio = 8'b11_00_00_00;
    req_m(0, 1);
    @(negedge clk);
    req_m(3, 1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(s_cyc[1] && owner(1) == 0, "R7 no preempt", owner(1), 0);
    end
    drop_m(0); drop_m(3);
    @(negedge clk); @(negedge clk);

    for (int i = 0; i < NM; i++) req_m(i, 3 - i);
    @(negedge clk);
    chk(s_cyc == 4'hF, "R9 all slaves", int'(s_cyc), 15);
    for (int k = 0; k < NS; k++)
      chk(owner(k) == 3 - k, "R9 concurrent owner", owner(k), 3 - k);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule